// File: doc/BRIEF.md
# Parallel SAR Converter Read Sequencer

This block sits on the host side of a memory-mapped parallel successive-approximation converter. It drives the converter's active-low select and read strobes. The converter uses the read strobe as its conversion trigger, so every read starts a new conversion. A one-cycle request starts one read sequence. The `mode_nowait` input, sampled when the request is accepted, picks one of two sequences.

In the held-read sequence (`mode_nowait` = 0), the strobes stay low across the whole conversion. The word is taken once the converter's busy line goes high again. In the short-read sequence (`mode_nowait` = 1), a brief strobe returns the result of the previous conversion and starts the next one. A programmable spacing, counted in conversion-clock periods, then keeps the next read away until that conversion has had time to finish.

The converter samples on the falling edges of its conversion clock. For that reason the sequencer aligns the falling edge of each read to a synchronized rising edge of that clock. It also drives a track/hold control for an external sample-and-hold, so the input is frozen before the converter responds.

Top module: `adc_read_seq`

## Requirements
- R1: While reset is asserted and in the cycle after, `adc_cs_n` and `adc_rd_n` are 1, `th_hold` and `rslt_valid` are 0, and `ready` is 1.
- R2: A request is accepted only in a cycle where `ready` is 1. `ready` is 1 only when no sequence is running and the spacing window has elapsed. A request while `ready` is 0 is ignored and produces no strobe.
- R3: `adc_rd_n` is never low while `adc_cs_n` is high. `adc_cs_n` falls at least one cycle before `adc_rd_n` falls, and it is still low in the cycle where `adc_rd_n` rises.
- R4: `adc_rd_n` falls only just after a rising edge of the synchronized conversion clock, so it falls while `conv_clk` is high.
- R5: With `mode_nowait` = 0, the strobes stay low until `adc_busy_n` has gone low and then high again. The word on `adc_data` at that point is reported with one `rslt_valid` pulse, and only then is `adc_rd_n` released.
- R6: With `mode_nowait` = 1, `adc_rd_n` stays low for STROBE_CYC cycles, or less if the synchronized conversion clock falls first. The word captured during the strobe is the result of the conversion before it.
- R7: A short read that follows reset, or that follows a held read, raises no `rslt_valid`. A short read that follows another short read reports its word.
- R8: After a short read releases its strobe, `ready` stays 0 and no new strobe occurs until GAP_CONV synchronized rising conversion-clock edges have passed.
- R9: `th_hold` goes to 1 in the same cycle that `adc_rd_n` falls. It stays 1 while the converter is busy and returns to 0 a few cycles after `adc_busy_n` rises.
- R10: `rslt_valid` lasts exactly one cycle, and each read produces at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle read request |
| mode_nowait | input | 1 | 0: held read, 1: short read; sampled with an accepted request |
| conv_clk | input | 1 | Converter conversion clock, asynchronous to clk |
| adc_busy_n | input | 1 | Converter busy line, low during a conversion |
| adc_data | input | 12 | Converter parallel data bus |
| ready | output | 1 | A request would be accepted this cycle |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_rd_n | output | 1 | Active-low read strobe and conversion trigger |
| th_hold | output | 1 | Sample-and-hold control, 1 = hold |
| rslt_valid | output | 1 | One-cycle pulse marking a reported word |
| rslt_data | output | 12 | Reported conversion word |

## Verification
The hardest states to reach from the ports are those where the sequencer must refuse work. One is a request that lands during the release cycle or inside the spacing window. The other is a short read whose returned word is stale because the previous read was a held one or there was none. The stimulus injects an extra request whenever `ready` is seen low during a sequence and then counts strobe falls per operation. It also mixes held and short reads in random order after directed pairs, so every ordering of the two modes is exercised. A converter model in the bench reacts to the strobes and produces known words, and the expected word for each read comes from the count of reads issued.

// File: rtl/ars_pkg.sv
package ars_pkg;

    localparam int WORD_W = 12;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ALIGN,
        SQ_WLO,
        SQ_WHI,
        SQ_NSTB,
        SQ_REL
    } sq_state_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } rd_result_t;

    function automatic int cnt_w(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic logic strobe_active(input sq_state_e s);
        return (s == SQ_WLO) || (s == SQ_WHI) || (s == SQ_NSTB);
    endfunction

endpackage

// File: rtl/ars_sync_edge.sv
module ars_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES:0] pipe;

    for (genvar gi = 0; gi <= STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= RST_VAL;
                else     pipe[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[gi] <= RST_VAL;
                else     pipe[gi] <= pipe[gi-1];
            end
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/ars_gap_timer.sv
module ars_gap_timer import ars_pkg::*; #(
    parameter int GAP = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int CW = cnt_w(GAP);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (load)                cnt <= CW'(GAP);
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/ars_strobe_fsm.sv
module ars_strobe_fsm import ars_pkg::*; #(
    parameter int STROBE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_nw,
    input  logic              ck_rise,
    input  logic              ck_high,
    input  logic              busy_lvl,
    input  logic [WORD_W-1:0] bus_data,
    output sq_state_e         state_o,
    output logic              mode_nw_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              arm_o,
    output logic              nw_release_o,
    output rd_result_t        res_o
);
    localparam int SCW = cnt_w(STROBE_CYC);

    sq_state_e      st, nxt;
    logic [SCW-1:0] scnt;
    logic           mode_q, primed_q, capture;

    always_comb begin
        nxt     = st;
        capture = 1'b0;
        unique case (st)
            SQ_IDLE:  if (start) nxt = SQ_ALIGN;
            SQ_ALIGN: if (ck_rise) nxt = mode_q ? SQ_NSTB : SQ_WLO;
            SQ_WLO:   if (!busy_lvl) nxt = SQ_WHI;
            SQ_WHI: begin
                if (busy_lvl) begin
                    nxt     = SQ_REL;
                    capture = 1'b1;
                end
            end
            SQ_NSTB: begin
                if (scnt == SCW'(STROBE_CYC - 1) || !ck_high) begin
                    nxt     = SQ_REL;
                    capture = 1'b1;
                end
            end
            SQ_REL:   nxt = SQ_IDLE;
            default:  nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            mode_q   <= 1'b0;
            primed_q <= 1'b0;
            scnt     <= '0;
            cs_n_o   <= 1'b1;
            rd_n_o   <= 1'b1;
            res_o    <= '0;
        end else begin
            st     <= nxt;
            cs_n_o <= (nxt == SQ_IDLE);
            rd_n_o <= !strobe_active(nxt);
            if (st == SQ_IDLE && start) mode_q <= start_nw;
            if (st == SQ_NSTB) scnt <= scnt + 1'b1;
            else               scnt <= '0;
            res_o.valid <= capture && (!mode_q || primed_q);
            if (capture) begin
                res_o.word <= bus_data;
                primed_q   <= mode_q;
            end
        end
    end

    assign state_o      = st;
    assign mode_nw_o    = mode_q;
    assign arm_o        = (st == SQ_ALIGN) && ck_rise;
    assign nw_release_o = (st == SQ_REL) && mode_q;
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq import ars_pkg::*; #(
    parameter int STROBE_CYC  = 4,
    parameter int GAP_CONV    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              mode_nowait,
    input  logic              conv_clk,
    input  logic              adc_busy_n,
    input  logic [WORD_W-1:0] adc_data,
    output logic              ready,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              th_hold,
    output logic              rslt_valid,
    output logic [WORD_W-1:0] rslt_data
);
    logic       ck_lvl, ck_rise, bz_lvl, bz_rise;
    logic       start, arm, nw_rel, gap_done, cur_mode_nw;
    sq_state_e  state;
    rd_result_t res;

    ars_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ck_sync (
        .clk(clk), .rst(rst), .din(conv_clk), .level(ck_lvl), .rise(ck_rise));

    ars_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bz_sync (
        .clk(clk), .rst(rst), .din(adc_busy_n), .level(bz_lvl), .rise(bz_rise));

    assign ready = (state == SQ_IDLE) && gap_done;
    assign start = req && ready;

    ars_strobe_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .start_nw(mode_nowait),
        .ck_rise(ck_rise), .ck_high(ck_lvl), .busy_lvl(bz_lvl), .bus_data(adc_data),
        .state_o(state), .mode_nw_o(cur_mode_nw), .cs_n_o(adc_cs_n), .rd_n_o(adc_rd_n),
        .arm_o(arm), .nw_release_o(nw_rel), .res_o(res));

    ars_gap_timer #(.GAP(GAP_CONV)) u_gap (
        .clk(clk), .rst(rst), .load(nw_rel), .tick(ck_rise), .done(gap_done));

    always_ff @(posedge clk) begin
        if (rst)          th_hold <= 1'b0;
        else if (arm)     th_hold <= 1'b1;
        else if (bz_rise) th_hold <= 1'b0;
    end

    assign rslt_valid = res.valid;
    assign rslt_data  = res.word;
endmodule

// File: rtl/ars_checker.sv
module ars_checker (
    input logic clk,
    input logic rst,
    input logic adc_cs_n,
    input logic adc_rd_n,
    input logic adc_busy_n,
    input logic th_hold,
    input logic rslt_valid,
    input logic ready,
    input logic mode_nw,
    input logic gap_done
);
    AST_READ_UNDER_SELECT: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n |-> !adc_cs_n); // R3
    AST_SELECT_LEADS_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_rd_n) |-> !$past(adc_cs_n)); // R3
    AST_SELECT_TRAILS_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_rd_n) |-> !adc_cs_n); // R3
    AST_HOLD_AT_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_rd_n) |-> th_hold); // R9
    AST_HELD_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_rd_n) && !mode_nw) |-> adc_busy_n); // R5
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rslt_valid |=> !rslt_valid); // R10
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ready |-> (adc_rd_n && adc_cs_n)); // R2
    AST_GAP_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !gap_done |-> adc_rd_n); // R8
endmodule

bind adc_read_seq ars_checker u_chk (
    .clk(clk), .rst(rst), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_busy_n(adc_busy_n), .th_hold(th_hold), .rslt_valid(rslt_valid),
    .ready(ready), .mode_nw(cur_mode_nw), .gap_done(gap_done));

// File: tb/adc_read_seq_tb.sv
module adc_read_seq_tb;
    localparam int STROBE_CYC = 4;
    localparam int GAP_CONV   = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        mode_nowait = 1'b0;
    logic        conv_clk = 1'b0;
    logic        adc_busy_n = 1'b1;
    logic [11:0] adc_data = 12'd0;
    logic        ready, adc_cs_n, adc_rd_n, th_hold, rslt_valid;
    logic [11:0] rslt_data;

    int n_chk = 0;
    int n_fail = 0;

    adc_read_seq #(.STROBE_CYC(STROBE_CYC), .GAP_CONV(GAP_CONV), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .req(req), .mode_nowait(mode_nowait), .conv_clk(conv_clk),
        .adc_busy_n(adc_busy_n), .adc_data(adc_data), .ready(ready), .adc_cs_n(adc_cs_n),
        .adc_rd_n(adc_rd_n), .th_hold(th_hold), .rslt_valid(rslt_valid), .rslt_data(rslt_data));

    always #2.5 clk = ~clk;
    initial begin
        #1;
        forever #100 conv_clk = ~conv_clk;
    end

    function automatic logic [11:0] conv_val(input int k);
        if (k == 0) return 12'd0;
        return 12'((k * 1103 + 517) ^ (k << 5));
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // converter model
    int model_cnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (!adc_cs_n && !adc_rd_n) begin
                model_cnt++;
                repeat (3) @(posedge clk);
                #1 adc_busy_n = 1'b0;
                @(negedge clk);
                chk(th_hold == 1'b1, "R9 hold while busy", th_hold, 1);
                repeat (13) @(negedge conv_clk);
                adc_data   = conv_val(model_cnt);
                adc_busy_n = 1'b1;
                repeat (4) @(posedge clk);
                @(negedge clk);
                chk(th_hold == 1'b0, "R9 track after busy", th_hold, 0);
                while (!adc_cs_n && !adc_rd_n) @(negedge clk);
            end
        end
    end

    // monitors
    int conv_rises = 0;
    always @(posedge conv_clk) conv_rises++;

    logic prev_rd = 1'b1;
    logic prev_ready = 1'b1;
    int   falls = 0, low_cnt = 0, last_low = 0, vcount = 0;
    int   rise_snap = 0, gap_meas = 0;
    logic [11:0] vdata = 12'd0;
    bit   rise_seen = 0, busy_at_rise = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_rd && !adc_rd_n) begin
                falls++;
                chk(conv_clk == 1'b1, "R4 read falls with conv clock high", conv_clk, 1);
                chk(th_hold == 1'b1, "R9 hold at read fall", th_hold, 1);
                chk(adc_cs_n == 1'b0, "R3 select low at read fall", adc_cs_n, 0);
            end
            if (!adc_rd_n) low_cnt++;
            if (!prev_rd && adc_rd_n) begin
                last_low     = low_cnt;
                low_cnt      = 0;
                busy_at_rise = adc_busy_n;
                rise_seen    = 1;
                rise_snap    = conv_rises;
            end
            if (!prev_ready && ready) gap_meas = conv_rises - rise_snap;
            if (rslt_valid) begin
                vcount++;
                vdata = rslt_data;
            end
            prev_rd    = adc_rd_n;
            prev_ready = ready;
        end
    end

    int n_started = 0;
    bit primed = 0;

    task automatic run_op(input bit nw, input bit inject);
        logic [11:0] exp_prev, exp_new;
        bit inj_done;
        inj_done = 0;
        while (!ready) @(negedge clk);
        falls = 0; vcount = 0; rise_seen = 0;
        req = 1'b1; mode_nowait = nw;
        @(negedge clk);
        req = 1'b0;
        n_started++;
        exp_prev = conv_val(n_started - 1);
        exp_new  = conv_val(n_started);
        while (!ready) begin
            if (inject && !inj_done && rise_seen) begin
                req = 1'b1; mode_nowait = $urandom % 2;
                @(negedge clk);
                req = 1'b0;
                inj_done = 1;
            end else begin
                @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        chk(falls == 1, "R2 one strobe per accepted request", falls, 1);
        chk(vcount <= 1, "R10 at most one valid pulse", vcount, 1);
        if (!nw) begin
            chk(vcount == 1, "R5 held read reports", vcount, 1);
            chk(vdata == exp_new, "R5 held read word", vdata, exp_new);
            chk(busy_at_rise == 1'b1, "R5 release after busy high", busy_at_rise, 1);
            primed = 0;
        end else begin
            chk(vcount == (primed ? 1 : 0), "R7 stale first short read", vcount, primed ? 1 : 0);
            if (primed) chk(vdata == exp_prev, "R6 short read returns prior word", vdata, exp_prev);
            chk(last_low == STROBE_CYC, "R6 short strobe width", last_low, STROBE_CYC);
            chk(gap_meas == GAP_CONV || gap_meas == GAP_CONV - 1,
                "R8 spacing window", gap_meas, GAP_CONV);
            primed = 1;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (6) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 select idle in reset", adc_cs_n, 1);
        chk(adc_rd_n == 1'b1, "R1 read idle in reset", adc_rd_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(th_hold == 1'b0, "R1 track after reset", th_hold, 0);
        chk(rslt_valid == 1'b0, "R1 no valid after reset", rslt_valid, 0);
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(adc_rd_n == 1'b1, "R1 read high after reset", adc_rd_n, 1);
        // directed corner orderings
        run_op(1'b1, 1'b1); // R7 first short read after reset
        run_op(1'b1, 1'b0); // R6 second short read reports
        run_op(1'b0, 1'b1); // R5 held read
        run_op(1'b1, 1'b0); // R7 short read after held read
        run_op(1'b1, 1'b1); // R8 request injected inside spacing window
        run_op(1'b0, 1'b0);
        run_op(1'b0, 1'b1);
        for (int i = 0; i < 36; i++) begin
            run_op(1'($urandom % 2), ($urandom % 3) == 0);
        end
        finish_run();
    end
endmodule